// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Fail-Safe

This block carries a single logic level across a channel that can only pass short pulses. The sending half synchronizes its input and, on every change, emits a narrow pulse on a "set" line (new level high) or a "clear" line (new level low). While the input stays quiet, it sends the present level again at a fixed interval, so a receiver that missed a pulse, or has just come out of reset, catches up without any help from the sending side.

The receiving half keeps a bistable output that the two pulse lines drive. It also runs a silence counter. When no usable pulse has arrived for a timeout longer than the refresh interval, the receiver decides the sender is dead and drives its output high, which is the fail-safe value. The next valid pulse, whether it marks an edge or is a refresh, takes control of the output back from the fail-safe.

Each half has its own synchronous reset, so a power loss on either side can be modelled on its own. The channel is brought out as ports (the sender's pulse outputs and the receiver's pulse inputs), and the system wires them together, directly or through the isolation barrier. All timing is set in nanoseconds and converted to clock cycles from the clock frequency parameter. With the defaults of 50 MHz, 2000 ns and 5000 ns, the refresh interval is 100 cycles and the watchdog timeout is 250 cycles. The refresh interval must be shorter than the watchdog timeout.

Top module: `edge_pulse_link`

## Requirements
- R1: After the input changes, the sender emits one pulse that starts on the third rising clock edge to sample the new level. A rise gives a pulse on `tx_set`, a fall gives a pulse on `tx_clr`.
- R2: Every pulse lasts exactly PULSE_CYC cycles (default 1). `tx_set` and `tx_clr` are never high in the same cycle.
- R3: A refresh pulse is sent when REFRESH_CYC cycles have passed since the last pulse request. Its line matches the synchronized level: `tx_set` for 1, `tx_clr` for 0. Refresh repeats at that interval while the input is idle. Any edge pulse restarts the interval.
- R4: On the first clock after the sender's reset is released, the sender emits a pulse for its synchronized level. That level is 0 because the synchronizer clears on reset, so this first pulse is on `tx_clr`.
- R5: One clock after the receiver samples `rx_set` alone high, `dout` is 1. One clock after it samples `rx_clr` alone high, `dout` is 0.
- R6: A cycle in which `rx_set` and `rx_clr` are both high is ignored. `dout` keeps its value, and the silence counter is not restarted.
- R7: After WDOG_CYC consecutive cycles without a valid pulse, `dout` is forced to 1 on the last of those edges. It stays at 1 until a valid pulse arrives.
- R8: While `rx_rst` is high, `dout` is 1 and the silence counter is cleared. While `tx_rst` is high, both pulse outputs are 0.
- R9: After either side leaves reset, `dout` equals the input again without any action from outside the block. For a sender restart this takes a few cycles. For a receiver restart it takes at most REFRESH_CYC + 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared by both halves |
| tx_rst | input | 1 | Synchronous active-high reset of the sending half |
| rx_rst | input | 1 | Synchronous active-high reset of the receiving half |
| din | input | 1 | Level to be carried (asynchronous) |
| tx_set | output | 1 | Sender pulse meaning "level is 1" |
| tx_clr | output | 1 | Sender pulse meaning "level is 0" |
| rx_set | input | 1 | Receiver set-pulse input from the channel |
| rx_clr | input | 1 | Receiver clear-pulse input from the channel |
| dout | output | 1 | Recovered level, fail-safe high |

## Verification
An input change shows up as a pulse on the third rising edge that samples it, and `dout` follows one edge after that. A refresh lands exactly REFRESH_CYC edges after the previous pulse request, and the fail-safe lands on the WDOG_CYC-th silent edge. The bench keeps a behavioural model that it steps at every rising edge from the same stimulus. It compares both pulse lines and `dout` with that model at every falling edge, so each of these latencies is checked in the exact cycle it is due. Directed checks count whole ticks from the falling edge where the stimulus was applied, and they cover the boot pulse, the restart of the refresh interval, conflicting pulses injected on the channel, and recovery after each side's reset.

// File: rtl/epl_pkg.sv
package epl_pkg;

  // Converts a time in nanoseconds to whole clock cycles at clk_hz.
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    return int'((clk_hz * ns) / 64'd1_000_000_000);
  endfunction

  // One beat on the two-wire pulse channel.
  typedef struct packed {
    logic set;
    logic clr;
  } pulse_pair_t;

endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/epl_tx.sv
module epl_tx #(
  parameter int unsigned REFRESH_CYC = 100,
  parameter int unsigned PULSE_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 din,
  output epl_pkg::pulse_pair_t pulse
);
  localparam int unsigned TW = (REFRESH_CYC > 1) ? $clog2(REFRESH_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(REFRESH_CYC - 1);
  localparam int unsigned RW = $clog2(PULSE_CYC + 1);
  localparam logic [RW-1:0] R_LOAD = RW'(PULSE_CYC - 1);

  logic          lvl;
  logic          lvl_prev;
  logic          boot_q;
  logic [TW-1:0] timer;
  logic [RW-1:0] remain;
  logic          set_q, clr_q;

  epl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (lvl)
  );

  logic edge_seen, refresh_due, fire;
  assign edge_seen   = lvl ^ lvl_prev;
  assign refresh_due = (timer == T_LAST);
  assign fire        = boot_q | edge_seen | refresh_due;

  // Level tracking and refresh interval timer
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_prev <= 1'b0;
      boot_q   <= 1'b1;
      timer    <= '0;
    end else begin
      lvl_prev <= lvl;
      boot_q   <= 1'b0;
      timer    <= fire ? '0 : timer + 1'b1;
    end
  end

  // Pulse shaper: a new request always overrides a pulse in progress
  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else if (fire) begin
      remain <= R_LOAD;
      set_q  <= lvl;
      clr_q  <= ~lvl;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end
  end

  assign pulse.set = set_q;
  assign pulse.clr = clr_q;

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(set_q && clr_q)); // R2
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
    (lvl && !lvl_prev) |=> set_q); // R1
  AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!lvl && lvl_prev) |=> clr_q); // R1
  AST_REFRESH_SENT: assert property (@(posedge clk) disable iff (rst)
    (timer == T_LAST) |=> (set_q || clr_q)); // R3
  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
    timer <= T_LAST); // R3
endmodule

// File: rtl/epl_rx.sv
module epl_rx #(
  parameter int unsigned WDOG_CYC = 250
) (
  input  logic                 clk,
  input  logic                 rst,
  input  epl_pkg::pulse_pair_t pulse,
  output logic                 dout
);
  localparam int unsigned WW = (WDOG_CYC > 1) ? $clog2(WDOG_CYC) : 1;
  localparam logic [WW-1:0] W_LAST = WW'(WDOG_CYC - 1);

  logic [WW-1:0] quiet;
  logic          out_q;
  logic          valid;

  assign valid = pulse.set ^ pulse.clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b1;
      quiet <= '0;
    end else if (valid) begin
      out_q <= pulse.set;
      quiet <= '0;
    end else if (quiet == W_LAST) begin
      out_q <= 1'b1;
    end else begin
      quiet <= quiet + 1'b1;
    end
  end

  assign dout = out_q;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pulse.set && !pulse.clr) |=> out_q); // R5
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (pulse.clr && !pulse.set) |=> !out_q); // R5
  AST_CONFLICT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pulse.set && pulse.clr && quiet != W_LAST) |=> $stable(out_q)); // R6
  AST_TIMEOUT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (quiet == W_LAST && !valid) |=> out_q); // R7
  AST_QUIET_RANGE: assert property (@(posedge clk) disable iff (rst)
    quiet <= W_LAST); // R7
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link #(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned REFRESH_NS  = 2000,
  parameter int unsigned WDOG_NS     = 5000,
  parameter int unsigned PULSE_CYC   = 1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic tx_rst,
  input  logic rx_rst,
  input  logic din,
  output logic tx_set,
  output logic tx_clr,
  input  logic rx_set,
  input  logic rx_clr,
  output logic dout
);
  localparam int unsigned REFRESH_CYC = epl_pkg::ns_to_cycles(CLK_HZ, REFRESH_NS);
  localparam int unsigned WDOG_CYC    = epl_pkg::ns_to_cycles(CLK_HZ, WDOG_NS);

  if (!(REFRESH_CYC < WDOG_CYC) || REFRESH_CYC < 2 || PULSE_CYC < 1 || SYNC_STAGES < 2) begin : g_bad_cfg
    $error("edge_pulse_link: refresh interval must be at least 2 cycles and shorter than the watchdog timeout");
  end

  epl_pkg::pulse_pair_t tx_p, rx_p;

  epl_tx #(
    .REFRESH_CYC (REFRESH_CYC),
    .PULSE_CYC   (PULSE_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_tx (
    .clk   (clk),
    .rst   (tx_rst),
    .din   (din),
    .pulse (tx_p)
  );

  assign tx_set   = tx_p.set;
  assign tx_clr   = tx_p.clr;
  assign rx_p.set = rx_set;
  assign rx_p.clr = rx_clr;

  epl_rx #(
    .WDOG_CYC (WDOG_CYC)
  ) u_rx (
    .clk   (clk),
    .rst   (rx_rst),
    .pulse (rx_p),
    .dout  (dout)
  );

  AST_RESET_FAILSAFE: assert property (@(posedge clk)
    rx_rst |=> dout); // R8
  AST_TX_QUIET_IN_RESET: assert property (@(posedge clk)
    tx_rst |=> (!tx_set && !tx_clr)); // R8
endmodule

// File: tb/sim_edge_pulse_link.sv
module sim_edge_pulse_link;
  localparam int R = 50_000_000 / 1000 * 2000 / 1_000_000; // 100
  localparam int T = 50_000_000 / 1000 * 5000 / 1_000_000; // 250
  localparam int W = 1;

  logic clk = 1'b0;
  logic tx_rst = 1'b1, rx_rst = 1'b1, din = 1'b0;
  logic inj_en = 1'b0, inj_set = 1'b0, inj_clr = 1'b0;
  logic tx_set, tx_clr, dout;
  wire  rx_set = inj_en ? inj_set : tx_set;
  wire  rx_clr = inj_en ? inj_clr : tx_clr;

  always #10 clk = ~clk;

  edge_pulse_link u0 (
    .clk(clk), .tx_rst(tx_rst), .rx_rst(rx_rst), .din(din),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr),
    .dout(dout)
  );

  int total = 0, bad = 0;
  bit armed = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: history of input samples, counters of cycles
  int hist[$];
  int since, left, quiet;
  bit boot, pol, m_set, m_clr, m_out, last_lvl;

  always @(posedge clk) begin
    bit cs, cc, lvl, want;
    // receiving side uses the channel as it stood before this edge
    cs = inj_en ? inj_set : m_set;
    cc = inj_en ? inj_clr : m_clr;
    if (rx_rst) begin
      m_out = 1; quiet = 0;
    end else if (cs != cc) begin
      m_out = cs; quiet = 0;
    end else if (quiet == T - 1) begin
      m_out = 1;
    end else begin
      quiet++;
    end
    // sending side
    if (tx_rst) begin
      hist = {0, 0}; last_lvl = 0; boot = 1; since = 0; left = 0; pol = 0;
    end else begin
      lvl  = hist[0][0];
      want = boot || (lvl != last_lvl) || (since == R - 1);
      last_lvl = lvl;
      void'(hist.pop_front());
      hist.push_back(int'(din));
      boot = 0;
      if (want) begin
        left = W; pol = lvl; since = 0;
      end else begin
        since++;
        if (left > 0) left--;
      end
    end
    m_set = (left > 0) && pol;
    m_clr = (left > 0) && !pol;
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      chk(tx_set == m_set, "R1 set line vs model", int'(tx_set), int'(m_set));
      chk(tx_clr == m_clr, "R1 clear line vs model", int'(tx_clr), int'(m_clr));
      chk(dout == m_out, "R5 output vs model", int'(dout), int'(m_out));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    tick(4);
    chk(dout == 1'b1, "R8 dout high in reset", int'(dout), 1);
    chk(!tx_set && !tx_clr, "R8 pulses low in reset", int'(tx_set | tx_clr), 0);
    tx_rst = 0; rx_rst = 0;
    tick(1);
    chk(tx_clr == 1'b1, "R4 boot clear pulse", int'(tx_clr), 1);
    tick(1);
    chk(dout == 1'b0, "R5 dout follows clear", int'(dout), 0);

    din = 1;
    tick(2);
    chk(tx_set == 1'b0, "R1 no early set", int'(tx_set), 0);
    tick(1);
    chk(tx_set == 1'b1, "R1 set on third edge", int'(tx_set), 1);
    tick(1);
    chk(tx_set == 1'b0, "R2 pulse one cycle", int'(tx_set), 0);
    chk(dout == 1'b1, "R5 dout follows set", int'(dout), 1);

    tick(98);
    chk(tx_set == 1'b0, "R3 no early refresh", int'(tx_set), 0);
    tick(1);
    chk(tx_set == 1'b1, "R3 refresh after interval", int'(tx_set), 1);
    tick(R);
    chk(tx_set == 1'b1, "R3 refresh repeats", int'(tx_set), 1);

    din = 0;
    tick(3);
    chk(tx_clr == 1'b1, "R1 clear on fall", int'(tx_clr), 1);
    tick(97);
    chk(!tx_set && !tx_clr, "R3 edge restarted interval", int'(tx_set | tx_clr), 0);
    tick(3);
    chk(tx_clr == 1'b1, "R3 refresh after restart", int'(tx_clr), 1);

    inj_en = 1; inj_set = 1; inj_clr = 1;
    tick(1);
    inj_set = 0; inj_clr = 0;
    chk(dout == 1'b0, "R6 conflict ignored", int'(dout), 0);
    tick(1);
    chk(dout == 1'b0, "R6 conflict ignored later", int'(dout), 0);
    tick(T + 5);
    chk(dout == 1'b1, "R7 fail-safe high", int'(dout), 1);
    tick(50);
    chk(dout == 1'b1, "R7 fail-safe held", int'(dout), 1);
    inj_en = 0;
    tick(R + 2);
    chk(dout == 1'b0, "R9 refresh restores level", int'(dout), 0);

    tx_rst = 1;
    tick(T + 20);
    chk(dout == 1'b1, "R7 dead sender fail-safe", int'(dout), 1);
    tx_rst = 0;
    tick(3);
    chk(dout == 1'b0, "R9 sender restart recovery", int'(dout), 0);

    rx_rst = 1;
    tick(3);
    chk(dout == 1'b1, "R8 receiver reset high", int'(dout), 1);
    rx_rst = 0;
    tick(R + 2);
    chk(dout == 1'b0, "R9 receiver restart recovery", int'(dout), 0);

    din = 1;
    tick(10);
    tx_rst = 1;
    tick(5);
    tx_rst = 0;
    tick(1);
    chk(tx_clr == 1'b1, "R4 boot pulse uses cleared level", int'(tx_clr), 1);
    tick(2);
    chk(tx_set == 1'b1, "R4 set after synchronizer fills", int'(tx_set), 1);
    tick(2);
    chk(dout == 1'b1, "R4 dout settles high", int'(dout), 1);

    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      din = ~din;
      tick((i % 50 == 49) ? 230 : int'(lf[2:0]) + 1);
    end
    tick(20);
    chk(dout == din, "R9 dout matches idle input", int'(dout), int'(din));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule